// File: doc/BRIEF.md
# ADC Calibration and Setup Sequencer

After power-up, this block brings a serial sign-magnitude ADC to a usable state. On a start pulse it sends the converter a fixed series of commands over a byte-level transaction port: it starts self-calibration, issues a status read whose data is thrown away, and waits for the end-of-conversion line to rise or for a timeout. It then reads the status word. If calibration has finished, it programs the sample-and-hold acquisition time. The sequence ends with a sticky `done_o` or a sticky `err_o`.

The block does not shift bits. It hands a command byte, plus a one-byte or two-byte length flag, to a separate serial engine, and that engine returns the received bytes together with a one-cycle completion pulse. The requested acquisition time, given in conversion-clock periods, and the converter variant are both captured on the start pulse. The wide (8-input) variant receives command bytes unchanged. The narrow (2-input) variant receives every command byte with its bits relocated.

Top module: `adc_cal_seq`

## Requirements
- R1: After reset `busy_o`, `done_o`, `err_o` and `xfer_req_o` are all 0.
- R2: A start pulse in idle runs transactions in this order: calibrate (byte 0x08, one byte), status read (byte 0x0C, two bytes) with its data discarded, an end-of-conversion wait, a second status read (0x0C, two bytes), then program-timing (one byte). `xfer_two_o` is 1 exactly for the status reads.
- R3: The wait ends within two cycles of a rising edge on `eoc_i`. A rising edge seen at any point after the start pulse, including during the calibrate or first status transaction, also ends the wait.
- R4: With no rising edge on `eoc_i`, the wait ends after `TIMEOUT_CYC` cycles. The timeout alone causes no error; the second status read is still issued.
- R5: The status word is {first received byte, bit 7 of the second byte}, 9 bits in total. If bit 6 of that word (bit 5 of the first byte) is 1, the sequence ends with `err_o`=1 and sends no program-timing command.
- R6: For the wide variant (`wide_i`=1), the program-timing byte is 0x0E for 6 clocks, 0x4E for 10, 0x8E for 18 and 0xCE for 34.
- R7: An acquisition setting of 0 is treated as 10 clocks.
- R8: Any acquisition setting other than 0, 6, 10, 18 or 34 ends the sequence after the second status read with `err_o`=1 and no program-timing command.
- R9: For the narrow variant (`wide_i`=0), every command byte c is sent as {c[7:6], c[3:0], 2'b00}. This gives calibrate 0x20, status 0x30, and timing bytes 0x38, 0x78, 0xB8 and 0xF8.
- R10: `done_o` and `err_o` are never both 1. Each stays at its value until the next start pulse, which clears both and raises `busy_o`. A start pulse while `busy_o`=1 has no effect.
- R11: While `xfer_req_o`=1 and `xfer_done_i`=0, the request, `xfer_cmd_o` and `xfer_two_o` all hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, acted on only while idle |
| wide_i | input | 1 | 1 = wide converter, 0 = narrow (remapped commands) |
| acq_clks_i | input | 6 | Acquisition time in conversion clocks (0 = default) |
| eoc_i | input | 1 | End-of-conversion line, synchronous to clk_i |
| xfer_req_o | output | 1 | Transaction request to the serial engine |
| xfer_cmd_o | output | 8 | Command byte to send |
| xfer_two_o | output | 1 | 1 = two-byte transaction |
| xfer_done_i | input | 1 | One-cycle completion pulse from the serial engine |
| xfer_rx0_i | input | 8 | First received byte, valid with xfer_done_i |
| xfer_rx1_i | input | 8 | Second received byte, valid with xfer_done_i |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sticky success flag |
| err_o | output | 1 | Sticky failure flag |

## Verification
The assertions assume the following about the inputs:
- `xfer_done_i` pulses for exactly one cycle, only while a request is up.
- `eoc_i` is already synchronous to `clk_i`.

The bench keeps to both. It answers each request with a single completion pulse two cycles after the request appears, and it changes `eoc_i` only on falling clock edges. It also sends start pulses into a busy sequence, raises `eoc_i` early, and withholds `eoc_i` altogether. In every case it compares the command stream against the values stated in the requirements.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int ACQ_W         = 6;
  localparam int STAT_W        = 9;
  localparam int STAT_BUSY_BIT = 6;

  localparam logic [7:0] CMD_CAL  = 8'h08;
  localparam logic [7:0] CMD_STAT = 8'h0C;

  typedef enum logic [2:0] {
    S_IDLE, S_CAL, S_DUMMY, S_WAIT, S_STAT, S_PROG
  } seq_state_t;

  // narrow device drops bits [5:4] and shifts the low nibble up
  function automatic logic [7:0] narrow_map(input logic [7:0] c);
    return {c[7:6], c[3:0], 2'b00};
  endfunction

  // {valid, code}
  function automatic logic [8:0] acq_lookup(input logic [ACQ_W-1:0] n);
    case (n)
      ACQ_W'(6):            return {1'b1, 8'h0E};
      ACQ_W'(0), ACQ_W'(10): return {1'b1, 8'h4E};
      ACQ_W'(18):           return {1'b1, 8'h8E};
      ACQ_W'(34):           return {1'b1, 8'hCE};
      default:              return {1'b0, 8'h0E};
    endcase
  endfunction
endpackage

// File: rtl/adc_seq_eoc.sv
module adc_seq_eoc (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic eoc_i,
  output logic seen_o
);
  logic eoc_q, seen_q;

  assign seen_o = seen_q | (eoc_i & ~eoc_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoc_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      eoc_q  <= eoc_i;
      seen_q <= clear_i ? 1'b0 : seen_o;
    end
  end

  a_r3_seen_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !clear_i) |=> seen_q);
  a_r3_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !seen_q);
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int unsigned TIMEOUT_CYC = 20_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end

  a_r4_expire_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o |-> $past(run_i));
  a_r4_restart_from_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/adc_seq_cmd.sv
module adc_seq_cmd
  import adc_seq_pkg::*;
(
  input  seq_state_t  state_i,
  input  logic        wide_i,
  input  logic [7:0]  acq_code_i,
  output logic        req_o,
  output logic        two_o,
  output logic [7:0]  cmd_o
);
  logic [7:0] raw;

  always_comb begin
    raw   = CMD_STAT;
    req_o = 1'b1;
    two_o = 1'b0;
    unique case (state_i)
      S_CAL:            raw = CMD_CAL;
      S_DUMMY, S_STAT:  two_o = 1'b1;
      S_PROG:           raw = acq_code_i;
      default:          req_o = 1'b0;
    endcase
  end

  assign cmd_o = wide_i ? raw : narrow_map(raw);
endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 20_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wide_i,
  input  logic [ACQ_W-1:0] acq_clks_i,
  input  logic             eoc_i,
  output logic             xfer_req_o,
  output logic [7:0]       xfer_cmd_o,
  output logic             xfer_two_o,
  input  logic             xfer_done_i,
  input  logic [7:0]       xfer_rx0_i,
  input  logic [7:0]       xfer_rx1_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  seq_state_t       state_q;
  logic             wide_q, done_q, err_q;
  logic [ACQ_W-1:0] acq_q;
  logic [8:0]       acq_lu;
  logic [STAT_W-1:0] status;
  logic             launch, in_wait, eoc_hit, tmr_exp;

  assign launch  = (state_q == S_IDLE) && start_i;
  assign in_wait = (state_q == S_WAIT);
  assign acq_lu  = acq_lookup(acq_q);
  assign status  = {xfer_rx0_i, xfer_rx1_i[7]};

  adc_seq_eoc u_eoc (
    .clk_i, .rst_ni, .clear_i(launch), .eoc_i, .seen_o(eoc_hit)
  );

  adc_seq_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk_i, .rst_ni, .run_i(in_wait), .expired_o(tmr_exp)
  );

  adc_seq_cmd u_cmd (
    .state_i(state_q), .wide_i(wide_q), .acq_code_i(acq_lu[7:0]),
    .req_o(xfer_req_o), .two_o(xfer_two_o), .cmd_o(xfer_cmd_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      wide_q  <= 1'b1;
      acq_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_CAL;
          wide_q  <= wide_i;
          acq_q   <= acq_clks_i;
          done_q  <= 1'b0;
          err_q   <= 1'b0;
        end
        S_CAL:   if (xfer_done_i) state_q <= S_DUMMY;
        S_DUMMY: if (xfer_done_i) state_q <= S_WAIT;
        // timeout falls through to the status check
        S_WAIT:  if (eoc_hit || tmr_exp) state_q <= S_STAT;
        S_STAT: if (xfer_done_i) begin
          if (status[STAT_BUSY_BIT] || !acq_lu[8]) begin
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_PROG;
          end
        end
        S_PROG: if (xfer_done_i) begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;

  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && !xfer_done_i) |=> xfer_req_o && $stable(xfer_cmd_o) && $stable(xfer_two_o));
  a_r10_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  a_r10_flags_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(done_o) && $stable(err_o));
  a_r10_busy_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o && !err_o);
  a_r9_narrow_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && !wide_q) |-> xfer_cmd_o[1:0] == 2'b00);
  a_r5_stuck_cal_errs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_STAT && xfer_done_i && status[STAT_BUSY_BIT]) |=> err_o && !busy_o);
  a_r2_prog_only_after_stat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PROG && !$past(state_q == S_PROG)) |-> $past(state_q == S_STAT));
endmodule

// File: tb/adc_cal_seq_test.sv
module adc_cal_seq_test;
  localparam int TO = 64;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wide = 1'b1, eoc = 1'b0, xdone = 1'b0;
  logic [5:0] acq = '0;
  logic [7:0] rx0 = '0, rx1 = '0;
  logic req, two, busy, done, err;
  logic [7:0] cmd;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  adc_cal_seq #(.TIMEOUT_CYC(TO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wide_i(wide), .acq_clks_i(acq),
    .eoc_i(eoc), .xfer_req_o(req), .xfer_cmd_o(cmd), .xfer_two_o(two),
    .xfer_done_i(xdone), .xfer_rx0_i(rx0), .xfer_rx1_i(rx1),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  // {wide[4], acq[8], rx0[8], rx1[8], eoc mode[4], poke[4], exp_err[4], prog[8]}
  // eoc mode: 0 = edge during wait, 1 = none (timeout), 2 = edge during calibrate
  localparam logic [47:0] VEC [15] = '{
    48'h1_06_00_00_0_0_0_0E,
    48'h1_0A_12_80_0_0_0_4E,
    48'h1_12_00_00_1_0_0_8E,
    48'h1_22_00_00_2_0_0_CE,
    48'h1_00_00_00_0_1_0_4E,
    48'h0_06_00_00_0_0_0_38,
    48'h0_0A_00_00_2_0_0_78,
    48'h0_12_00_00_0_0_0_B8,
    48'h0_22_00_00_0_1_0_F8,
    48'h0_00_00_00_0_0_0_78,
    48'h1_0A_20_00_0_0_1_00,
    48'h1_0A_DF_FF_0_0_0_4E,
    48'h1_07_00_00_0_0_1_00,
    48'h0_3F_00_00_2_0_1_00,
    48'h1_0A_20_00_1_0_1_00
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_req(input int lim, output int n);
    n = 0;
    while (!req && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic serve(input logic [7:0] ecmd, input bit etwo,
                       input logic [7:0] d0, input logic [7:0] d1, input string tag);
    int n;
    bit held;
    wait_req(40, n);
    chk(req && cmd == ecmd, {tag, " R2 command byte"}, cmd, ecmd);
    chk(two == etwo, {tag, " R2 length"}, two, etwo);
    held = 1'b1;
    repeat (2) begin
      @(negedge clk);
      if (!req || cmd != ecmd || two != etwo) held = 1'b0;
    end
    chk(held, "R11 request held until done", held, 1);
    rx0 = d0; rx1 = d1; xdone = 1'b1;
    @(negedge clk);
    xdone = 1'b0; rx0 = '0; rx1 = '0;
  endtask

  task automatic run_case(input logic [47:0] v);
    logic [7:0] ecal, est;
    int n;
    bit ok;
    wide = v[44];
    acq  = v[41:36];
    ecal = wide ? 8'h08 : 8'h20;
    est  = wide ? 8'h0C : 8'h30;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !done && !err, "R10 start clears flags", {busy, done, err}, 3'b100);
    if (v[19:16] == 4'd2) eoc = 1'b1;
    if (v[12]) begin
      start = 1'b1; wide = ~wide; acq = 6'd7;
      @(negedge clk); start = 1'b0;
    end
    serve(ecal, 1'b0, 8'hA5, 8'h00, "cal R9");
    eoc = 1'b0;
    serve(est, 1'b1, 8'hFF, 8'hFF, "dummy R9");
    case (v[19:16])
      4'd0: begin
        repeat (3) @(negedge clk);
        chk(!req, "R3 waits for end of conversion", req, 0);
        eoc = 1'b1;
        wait_req(10, n);
        eoc = 1'b0;
        chk(req && n <= 2, "R3 edge ends wait", n, 1);
      end
      4'd1: begin
        wait_req(TO + 20, n);
        chk(req && n >= TO - 2 && n <= TO + 3, "R4 timeout length", n, TO);
      end
      default: begin
        wait_req(10, n);
        chk(req && n <= 2, "R3 early edge counted", n, 1);
      end
    endcase
    serve(est, 1'b1, v[35:28], v[27:20], "status R5");
    if (v[11:8] == 4'd0) begin
      serve(v[7:0], 1'b0, 8'h00, 8'h00, "program R6 R7 R9");
      chk(done && !err && !busy, "R6 done raised", {busy, done, err}, 3'b010);
    end else begin
      chk(err && !done && !busy && !req, "R5/R8 error, no program", {req, busy, done, err}, 4'b0001);
    end
    ok = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (req || busy || done != (v[11:8] == 0) || err != (v[11:8] != 0)) ok = 1'b0;
    end
    chk(ok, "R10 flags sticky while idle", ok, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !req, "R1 reset state", {req, busy, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && !req, "R1 idle after reset", {req, busy, done, err}, 0);

    for (int i = 0; i < 15; i++) run_case(VEC[i]);

    // reset in the middle of the wait
    wide = 1'b1; acq = 6'd10;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    serve(8'h08, 1'b0, 8'h00, 8'h00, "R2 pre-reset cal");
    serve(8'h0C, 1'b1, 8'h00, 8'h00, "R2 pre-reset dummy");
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err && !req, "R1 reset aborts run", {req, busy, done, err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_case(48'h1_06_00_00_0_0_0_0E);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule